// File: doc/BRIEF.md
# Dual-Bank Hashed Recent-Requests Table

This block remembers line tags that were requested recently, so that an offset-learning prefetcher can ask whether a prefetch at some candidate offset would have arrived in time. Storage is split into two direct-mapped banks. Each bank has its own write source and its own index hash. The left bank takes base tags from the demand stream, and those tags may already have passed through an external delay. The right bank takes hardware-prefetch fills. For each fill it stores the fill tag with the active best offset subtracted, and it only does so while prefetching is switched on.

A lookup presents a 12-bit key. The block reads the hashed slot in both banks in parallel and compares the stored tags with the key. Two cycles later it reports a hit per bank and a combined hit. A write always overwrites its slot: there is no replacement choice and no eviction tracking. The memories have no reset and are arranged so that block RAM can be inferred. A separate valid-bit vector per bank is cleared by a synchronous reset. The choice of what to insert and when to insert it belongs to the surrounding prefetcher.

Top module: `recent_tag_table`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `hit_valid` is 0. After a reset every slot of both banks is empty, so any lookup misses in both banks.
- R2: A left write of tag T is stored on that clock edge. A later lookup of T, presented with `lookup_valid` high at edge N, gives `hit_valid`=1 and `hit_left`=1 after edge N+1.
- R3: The left bank's slot index is `(T ^ (T >> 6)) mod 64`. A write to an occupied slot replaces the old tag. For example, tags 0x001 and 0x040 share left slot 1, so after writing 0x001 and then 0x040 a lookup of 0x001 misses on the left side.
- R4: The right bank's slot index is `((T >> 1) ^ (T >> 7)) mod 64`, and a write replaces the old tag. For example, 0x002 and 0x003 share right slot 1.
- R5: The right bank is written only in a cycle where `fill_valid`, `fill_is_prefetch` and `pf_enable` are all 1. If any of them is 0, the fill leaves the table unchanged.
- R6: The value stored in the right bank is `(fill_tag - best_offset) mod 4096`, with `best_offset` read as two's complement. Two examples: fill 0x000 with offset 1 stores 0xFFF, and fill 0x002 with offset 0xFFD (-3) stores 0x005.
- R7: `hit_left` and `hit_right` report matches in each bank separately. `hit` is their OR.
- R8: If a lookup and a write reach the same slot in the same cycle, the lookup compares against the slot's contents from before the write.
- R9: `hit_valid` is high exactly two cycles after a cycle with `lookup_valid` high. When `hit_valid` is 0, all three hit flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| left_wr_en | input | 1 | Write the left bank this cycle |
| left_wr_tag | input | 12 | Base tag written to the left bank |
| fill_valid | input | 1 | A line fill arrives this cycle |
| fill_is_prefetch | input | 1 | The fill was caused by a hardware prefetch |
| pf_enable | input | 1 | Prefetching is currently switched on |
| fill_tag | input | 12 | Tag of the filled line |
| best_offset | input | 12 | Active best offset, two's complement |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_key | input | 12 | Tag to search for |
| hit_valid | output | 1 | A lookup result is present |
| hit | output | 1 | Key found in either bank |
| hit_left | output | 1 | Key found in the left bank |
| hit_right | output | 1 | Key found in the right bank |

## Verification
The hardest case to reach from the ports is a lookup and a write landing on the same slot in the same clock cycle. To produce it, the bench first fills a left slot with one tag. In a single cycle it then writes a second tag that hashes to the same slot and looks up the first tag, and it expects the old tag to hit. It repeats this against an empty slot and expects a miss. Collisions are built from tag pairs chosen to share a hashed index, and each bank gets its own pair because the two banks hash differently. Negative and wrapping offsets are checked through the value stored in the right bank.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int unsigned RTT_NUM_BANKS = 2;
  typedef enum logic {
    RTT_LEFT  = 1'b0,
    RTT_RIGHT = 1'b1
  } rtt_bank_e;
endpackage

// File: rtl/rtt_index_hash.sv
module rtt_index_hash #(
  parameter int unsigned TAG_W = 12,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned SHIFT = 0
) (
  input  logic [TAG_W-1:0] tag_i,
  output logic [IDX_W-1:0] idx_o
);
  // fold the shifted tag onto itself at the index width
  assign idx_o = IDX_W'((tag_i >> SHIFT) ^ ((tag_i >> SHIFT) >> IDX_W));
endmodule

// File: rtl/rtt_bank.sv
module rtt_bank #(
  parameter int unsigned TAG_W   = 12,
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_vld
);
  logic [TAG_W-1:0] mem [ENTRIES];
  logic [ENTRIES-1:0] vld;

  // storage without reset, read-first registered port
  always_ff @(posedge clk) begin
    if (wr_en && !rst) mem[wr_idx] <= wr_tag;
    rd_tag <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= 1'b1;
      rd_vld <= vld[rd_idx];
    end
  end

  AST_VALID_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld == '0)); // R1
  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld[$past(wr_idx)]); // R2
endmodule

// File: rtl/recent_tag_table.sv
module recent_tag_table
  import rtt_pkg::*;
#(
  parameter int unsigned TAG_W   = 12,
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned NB     = RTT_NUM_BANKS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             left_wr_en,
  input  logic [TAG_W-1:0] left_wr_tag,
  input  logic             fill_valid,
  input  logic             fill_is_prefetch,
  input  logic             pf_enable,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [TAG_W-1:0] best_offset,
  input  logic             lookup_valid,
  input  logic [TAG_W-1:0] lookup_key,
  output logic             hit_valid,
  output logic             hit,
  output logic             hit_left,
  output logic             hit_right
);
  logic             bank_we  [NB];
  logic [TAG_W-1:0] bank_wd  [NB];
  logic [TAG_W-1:0] bank_rd  [NB];
  logic             bank_rv  [NB];
  logic [NB-1:0]    bank_match;
  logic             look_q;
  logic [TAG_W-1:0] key_q;

  // write sources: demand tags on the left, offset-corrected fills on the right
  always_comb begin
    bank_we[int'(RTT_LEFT)]  = left_wr_en;
    bank_wd[int'(RTT_LEFT)]  = left_wr_tag;
    bank_we[int'(RTT_RIGHT)] = fill_valid && fill_is_prefetch && pf_enable;
    bank_wd[int'(RTT_RIGHT)] = fill_tag - best_offset;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [IDX_W-1:0] widx;
    logic [IDX_W-1:0] ridx;

    rtt_index_hash #(.TAG_W(TAG_W), .IDX_W(IDX_W), .SHIFT(b)) u_whash (
      .tag_i(bank_wd[b]), .idx_o(widx));
    rtt_index_hash #(.TAG_W(TAG_W), .IDX_W(IDX_W), .SHIFT(b)) u_rhash (
      .tag_i(lookup_key), .idx_o(ridx));

    rtt_bank #(.TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (bank_we[b]),
      .wr_idx (widx),
      .wr_tag (bank_wd[b]),
      .rd_idx (ridx),
      .rd_tag (bank_rd[b]),
      .rd_vld (bank_rv[b])
    );

    assign bank_match[b] = look_q && bank_rv[b] && (bank_rd[b] == key_q);
  end

  // stage 1: key travels alongside the bank read
  always_ff @(posedge clk) begin
    if (rst) look_q <= 1'b0;
    else     look_q <= lookup_valid;
    key_q <= lookup_key;
  end

  // stage 2: registered compare results
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit       <= 1'b0;
      hit_left  <= 1'b0;
      hit_right <= 1'b0;
    end else begin
      hit_valid <= look_q;
      hit       <= |bank_match;
      hit_left  <= bank_match[int'(RTT_LEFT)];
      hit_right <= bank_match[int'(RTT_RIGHT)];
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit_valid); // R1
  AST_HIT_MERGE: assert property (@(posedge clk) disable iff (rst)
    hit == (hit_left || hit_right)); // R7
  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (hit || hit_left || hit_right) |-> hit_valid); // R9
endmodule

// File: tb/recent_tag_table_bench.sv
`timescale 1ns/1ps
module recent_tag_table_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        left_wr_en, fill_valid, fill_is_prefetch, pf_enable, lookup_valid;
  logic [11:0] left_wr_tag, fill_tag, best_offset, lookup_key;
  logic        hit_valid, hit, hit_left, hit_right;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  recent_tag_table u_recent_tag_table (
    .clk(clk), .rst(rst),
    .left_wr_en(left_wr_en), .left_wr_tag(left_wr_tag),
    .fill_valid(fill_valid), .fill_is_prefetch(fill_is_prefetch),
    .pf_enable(pf_enable), .fill_tag(fill_tag), .best_offset(best_offset),
    .lookup_valid(lookup_valid), .lookup_key(lookup_key),
    .hit_valid(hit_valid), .hit(hit), .hit_left(hit_left), .hit_right(hit_right)
  );

  // {req, op, tag, offset, ctl{pf_enable,is_prefetch}, exp{left,right}}
  // op: 1 left write, 2 fill, 3 lookup
  localparam int NV = 21;
  localparam logic [39:0] VEC [NV] = '{
    40'h1300100000, // R1 empty table misses
    40'h2100100000, // R2 left write 0x001
    40'h2300100002, // R2 lookup hits left
    40'h3104000000, // R3 0x040 shares left slot 1
    40'h3300100000, // R3 0x001 replaced
    40'h3304000002, // R3 0x040 present
    40'h6200700530, // R6 fill 0x007 - 5 = 0x002
    40'h6300200001, // R6 right hit
    40'h4200800530, // R4 fill 0x008 - 5 = 0x003, right slot 1
    40'h4300200000, // R4 0x002 replaced
    40'h4300300001, // R4 0x003 present
    40'h5210000010, // R5 fill with prefetching off
    40'h5310000000, // R5 nothing stored
    40'h5210000020, // R5 demand fill
    40'h5310000000, // R5 nothing stored
    40'h6200000130, // R6 0x000 - 1 wraps
    40'h63FFF00001, // R6 0xFFF present
    40'h62002FFD30, // R6 negative offset -3
    40'h6300500001, // R6 0x005 present
    40'h7100500000, // R7 left write 0x005
    40'h7300500003  // R7 both banks hit
  };

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    left_wr_en = 0; fill_valid = 0; fill_is_prefetch = 0; pf_enable = 0;
    lookup_valid = 0; left_wr_tag = '0; fill_tag = '0; best_offset = '0;
    lookup_key = '0;
  endtask

  task automatic left_write(input logic [11:0] t);
    left_wr_en = 1; left_wr_tag = t;
    @(negedge clk);
    left_wr_en = 0;
  endtask

  task automatic fill(input logic [11:0] t, input logic [11:0] off, input logic [3:0] ctl);
    fill_valid = 1; fill_tag = t; best_offset = off;
    pf_enable = ctl[1]; fill_is_prefetch = ctl[0];
    @(negedge clk);
    fill_valid = 0; pf_enable = 0; fill_is_prefetch = 0;
  endtask

  // presents the key at edge N, samples after edge N+1
  task automatic lookup(input logic [11:0] k, input string req, input logic [1:0] exp);
    lookup_valid = 1; lookup_key = k;
    @(negedge clk);
    lookup_valid = 0; left_wr_en = 0;
    @(negedge clk);
    check(hit_valid == 1'b1, "R9 result present", int'(hit_valid), 1);
    check({hit_left, hit_right} == exp, req, int'({hit_left, hit_right}), int'(exp));
    check(hit == |exp, "R7 combined hit", int'(hit), int'(|exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    check(hit_valid == 1'b0, "R1 no result in reset", int'(hit_valid), 0);
    rst = 0;
    @(negedge clk);
    check(hit_valid == 1'b0, "R1 no result after reset", int'(hit_valid), 0);

    for (int i = 0; i < NV; i++) begin
      automatic logic [3:0]  rq  = VEC[i][39:36];
      automatic logic [3:0]  op  = VEC[i][35:32];
      automatic logic [11:0] tg  = VEC[i][31:20];
      automatic logic [11:0] off = VEC[i][19:8];
      automatic logic [3:0]  ctl = VEC[i][7:4];
      automatic logic [1:0]  ex  = VEC[i][1:0];
      case (op)
        4'h1: left_write(tg);
        4'h2: fill(tg, off, ctl);
        default: lookup(tg, $sformatf("R%0d vector %0d", rq, i), ex);
      endcase
    end

    // R9: idle cycles give no result and no hit flags
    repeat (2) @(negedge clk);
    check({hit_valid, hit, hit_left, hit_right} == 4'b0, "R9 idle outputs",
          int'({hit_valid, hit, hit_left, hit_right}), 0);

    // R8: 0x044 targets left slot 5 holding 0x005; same-cycle lookup sees 0x005
    left_wr_en = 1; left_wr_tag = 12'h044;
    lookup(12'h005, "R8 old tag still seen", 2'b11);
    lookup(12'h044, "R8 new tag after write", 2'b10);
    lookup(12'h005, "R8 old tag replaced on left", 2'b01);
    // R8: write into empty left slot 3 while looking it up
    left_wr_en = 1; left_wr_tag = 12'h0C0;
    lookup(12'h0C0, "R8 empty slot seen", 2'b00);
    lookup(12'h0C0, "R8 write landed", 2'b10);

    // R1: reset empties both banks
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    lookup(12'h040, "R1 left emptied", 2'b00);
    lookup(12'h003, "R1 right emptied", 2'b00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule